// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block produces the array address that a synchronous burst SRAM uses in each clock cycle. It samples an external address bus together with two burst-start strobes, an advance strobe, a chip enable and an order select, all on the rising clock edge. One start strobe belongs to the processor side and the other to the memory-controller side. A start loads the external address as the first beat. After that, the two low address bits step through a four-beat pattern, either linear or interleaved, in each cycle where the advance strobe is high. The upper bits do not change during a burst.

A new address can be loaded in any cycle, including the middle of a burst, and no dead cycle is inserted, so a system that never uses bursts still gets one access per cycle. The output address and its valid flag come from registers and appear one clock after the inputs are sampled. The order select is captured when a burst starts, so changing it later does not affect a burst already in progress.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, `addr_vld` is 0 and `arr_addr` is all zeros.
- R2: When `start_cpu` is 1 and `cs_en` is 1 at an edge, `arr_addr` equals the sampled `ext_addr` and `addr_vld` is 1 after that edge. This is beat 0 of the burst.
- R3: When `start_ctl` is 1, `start_cpu` is 0 and `cs_en` is 1 at an edge, the address is loaded in the same way as in R2.
- R4: `start_cpu` has priority over `start_ctl`. When both are 1 and `cs_en` is 0, the control-side deselect does not happen, and `arr_addr` and `addr_vld` keep their values.
- R5: During a valid burst with no effective start, `adv`=1 moves the address one beat forward at the next edge. `adv`=0 keeps the address unchanged.
- R6: When `start_ctl` is 1, `start_cpu` is 0 and `cs_en` is 0, `addr_vld` goes to 0 and `arr_addr` keeps its value.
- R7: When `start_cpu` is 1 and `cs_en` is 0, the processor-side strobe is ignored, and with `adv`=0 `arr_addr` and `addr_vld` stay unchanged.
- R8: With `ord_sel`=1 sampled at the start (linear order), beat k has low bits (start low bits + k) mod 4. A change of `ord_sel` during the burst has no effect.
- R9: With `ord_sel`=0 sampled at the start (interleaved order, which is the default encoding), beat k has low bits equal to the start low bits XOR k.
- R10: Address bits above bit 1 never change within a burst. After the fourth beat the sequence wraps back to the first beat.
- R11: A start in the middle of a burst loads the new address at the next edge, with no gap cycle.
- R12: `adv` has no effect in a cycle that has an effective start, and it has no effect while `addr_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_addr | input | ADDR_W | External address bus |
| start_cpu | input | 1 | Processor-side burst start strobe |
| start_ctl | input | 1 | Controller-side burst start strobe |
| adv | input | 1 | Advance strobe, steps to the next beat |
| cs_en | input | 1 | Chip enable |
| ord_sel | input | 1 | Burst order: 1 linear, 0 interleaved |
| arr_addr | output | ADDR_W | Array address for the current cycle |
| addr_vld | output | 1 | Array address is valid |

## Verification
A wrong beat count or a wrong latched order bit shows as wrong low bits on `arr_addr` one edge after the next advance, and it stays wrong until a new start loads a fresh address. A wrong base register or a wrong priority decode shows at the edge right after the strobe: `arr_addr` or `addr_vld` takes the wrong value immediately. A counter that keeps stepping while no burst is active stays hidden until a later burst. For that reason the bench advances while invalid and then checks the held address.

// File: rtl/burst_seq_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes a four-beat burst, so the beat counter is two bits wide.
package burst_seq_pkg;
    localparam int BEAT_W = 2;

    // Action that the start decode selects for a cycle
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_DESEL = 2'd2
    } seq_act_e;

    // Burst order latched at burst start
    typedef enum logic {
        ORD_INTLV = 1'b0,
        ORD_LIN   = 1'b1
    } seq_ord_e;
endpackage

// File: rtl/burst_start_arb.sv
// Module: decodes the two start strobes, chip enable and advance into one
// action and one step request. The processor side wins when both strobes are
// high. A processor start while disabled is ignored. A controller start
// while disabled deselects. Purely combinational.
module burst_start_arb
    import burst_seq_pkg::*;
(
    input  logic     start_cpu,
    input  logic     start_ctl,
    input  logic     cs_en,
    input  logic     adv,
    output seq_act_e act,
    output logic     step
);
    // Priority decode of the start strobes
    always_comb begin
        if (start_cpu) begin
            act = cs_en ? ACT_LOAD : ACT_HOLD;
        end else if (start_ctl) begin
            act = cs_en ? ACT_LOAD : ACT_DESEL;
        end else begin
            act = ACT_HOLD;
        end
    end

    // Advance only in cycles where nothing else happens
    always_comb begin
        step = adv && (act == ACT_HOLD);
    end
endmodule

// File: rtl/burst_beat_ctr.sv
// Module: holds the loaded base address, the beat counter, the latched order
// and the valid flag. Assumes the arbiter has already resolved priority.
// The beat counter wraps at four and never carries into the base.
module burst_beat_ctr
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_act_e          act,
    input  logic              step,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ord_sel,
    output logic [ADDR_W-1:0] base,
    output logic [BEAT_W-1:0] beat,
    output seq_ord_e          ord,
    output logic              vld
);
    // Register update per decoded action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            beat <= '0;
            ord  <= ORD_INTLV;
            vld  <= 1'b0;
        end else begin
            unique case (act)
                ACT_LOAD: begin
                    base <= ext_addr;
                    beat <= '0;
                    ord  <= seq_ord_e'(ord_sel);
                    vld  <= 1'b1;
                end
                ACT_DESEL: vld <= 1'b0;
                default: begin
                    if (step && vld) beat <= beat + 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/burst_order_map.sv
// Module: maps base address, beat count and order to the array address.
// Linear order adds the beat to the low bits modulo four. Interleaved order
// XORs the beat into them. The upper bits pass through unchanged.
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [BEAT_W-1:0] beat,
    input  seq_ord_e          ord,
    output logic [ADDR_W-1:0] addr
);
    logic [BEAT_W-1:0] low;

    // Low-bit sequencing per order
    always_comb begin
        if (ord == ORD_LIN) low = base[BEAT_W-1:0] + beat;
        else                low = base[BEAT_W-1:0] ^ beat;
    end

    // Recombine with the fixed upper bits
    always_comb begin
        addr = {base[ADDR_W-1:BEAT_W], low};
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Module: top of the burst address sequencer. All inputs are sampled on the
// rising edge. Outputs are registered-state based, so they appear one edge
// after sampling. Assumes ADDR_W is greater than the beat width.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              start_cpu,
    input  logic              start_ctl,
    input  logic              adv,
    input  logic              cs_en,
    input  logic              ord_sel,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              addr_vld
);
    seq_act_e          act;
    logic              step;
    logic [ADDR_W-1:0] base;
    logic [BEAT_W-1:0] beat;
    seq_ord_e          ord;

    burst_start_arb u_arb (
        .start_cpu(start_cpu), .start_ctl(start_ctl), .cs_en(cs_en),
        .adv(adv), .act(act), .step(step)
    );

    burst_beat_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .act(act), .step(step),
        .ext_addr(ext_addr), .ord_sel(ord_sel),
        .base(base), .beat(beat), .ord(ord), .vld(addr_vld)
    );

    burst_order_map #(.ADDR_W(ADDR_W)) u_map (
        .base(base), .beat(beat), .ord(ord), .addr(arr_addr)
    );
endmodule

// File: rtl/burst_addr_seq_chk.sv
// Module: port-level properties of the burst address sequencer, bound to
// every instance of the top module.
module burst_addr_seq_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              start_cpu,
    input logic              start_ctl,
    input logic              adv,
    input logic              cs_en,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              addr_vld
);
    // R1: reset clears the valid flag
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !addr_vld);

    // R2: processor start loads the external address
    a_r2_cpu_load: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cpu && cs_en) |=> (addr_vld && arr_addr == $past(ext_addr)));

    // R4: both strobes while disabled leave state alone
    a_r4_cpu_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cpu && start_ctl && !cs_en && !adv) |=> ($stable(addr_vld) && $stable(arr_addr)));

    // R5: no advance and no start holds the address
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_cpu && !start_ctl && !adv) |=> $stable(arr_addr));

    // R6: controller start while disabled deselects
    a_r6_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ctl && !start_cpu && !cs_en) |=> !addr_vld);

    // R10: upper bits fixed within a burst
    a_r10_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_cpu && !start_ctl) |=> (arr_addr[ADDR_W-1:2] == $past(arr_addr[ADDR_W-1:2])));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .start_cpu(start_cpu),
    .start_ctl(start_ctl), .adv(adv), .cs_en(cs_en),
    .arr_addr(arr_addr), .addr_vld(addr_vld)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          start_cpu = 1'b0, start_ctl = 1'b0, adv = 1'b0;
    logic          cs_en = 1'b0, ord_sel = 1'b0;
    logic [AW-1:0] arr_addr;
    logic          addr_vld;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .start_cpu(start_cpu),
        .start_ctl(start_ctl), .adv(adv), .cs_en(cs_en), .ord_sel(ord_sel),
        .arr_addr(arr_addr), .addr_vld(addr_vld)
    );

    typedef struct packed {
        logic       cpu, ctl, cs, adv, ord;
        logic [7:0] addr;
        logic       evld;
        logic [7:0] eaddr;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{1,0,1,0,1, 8'h35, 1, 8'h35, 8'd2},  // R2 cpu load, linear
        '{0,0,0,1,1, 8'h00, 1, 8'h36, 8'd8},  // R8 beat 1
        '{0,0,0,1,1, 8'h00, 1, 8'h37, 8'd8},  // R8 beat 2
        '{0,0,0,0,1, 8'h00, 1, 8'h37, 8'd5},  // R5 hold
        '{0,0,0,1,1, 8'h00, 1, 8'h34, 8'd10}, // R10 beat 3 upper fixed
        '{0,0,0,1,1, 8'h00, 1, 8'h35, 8'd10}, // R10 wrap to first
        '{0,1,1,0,0, 8'hA6, 1, 8'hA6, 8'd3},  // R3 R11 ctl load mid-burst
        '{0,0,0,1,0, 8'h00, 1, 8'hA7, 8'd9},  // R9 10^01
        '{0,0,0,1,0, 8'h00, 1, 8'hA4, 8'd9},  // R9 10^10
        '{0,0,0,1,0, 8'h00, 1, 8'hA5, 8'd9},  // R9 10^11
        '{1,1,0,0,0, 8'h77, 1, 8'hA5, 8'd4},  // R4 cpu wins, no deselect
        '{1,0,0,0,0, 8'h55, 1, 8'hA5, 8'd7},  // R7 cpu ignored
        '{1,0,1,1,1, 8'h62, 1, 8'h62, 8'd12}, // R12 start beats adv
        '{0,1,0,0,0, 8'h99, 0, 8'h62, 8'd6},  // R6 deselect
        '{0,0,0,1,0, 8'h00, 0, 8'h62, 8'd12}, // R12 adv while invalid
        '{1,0,1,0,0, 8'hC0, 1, 8'hC0, 8'd11}  // R11 back-to-back start
    };

    task automatic check(input int req, input logic ev, input logic [AW-1:0] ea);
        checks++;
        if (addr_vld !== ev || arr_addr !== ea) begin
            errors++;
            $display("FAIL R%0d: vld=%0b addr=%02h expected vld=%0b addr=%02h",
                     req, addr_vld, arr_addr, ev, ea);
        end
    endtask

    task automatic drive(input logic c, input logic t, input logic e,
                         input logic a, input logic o, input logic [AW-1:0] ad);
        start_cpu = c; start_ctl = t; cs_en = e; adv = a; ord_sel = o; ext_addr = ad;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1, 1'b0, '0);                    // R1 in reset
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(1, 1'b0, '0);                    // R1 first cycle after reset
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].cpu, TBL[i].ctl, TBL[i].cs, TBL[i].adv, TBL[i].ord, TBL[i].addr);
            check(int'(TBL[i].req), TBL[i].evld, TBL[i].eaddr);
        end
        // R8: order latched at start, later ord_sel change ignored
        drive(0, 1, 1, 0, 1, 8'h3E); check(8, 1'b1, 8'h3E);
        drive(0, 0, 0, 1, 0, 8'h00); check(8, 1'b1, 8'h3F);
        drive(0, 0, 0, 1, 0, 8'h00); check(8, 1'b1, 8'h3C);
        // R9: interleave from low bits 11
        drive(1, 0, 1, 0, 0, 8'h4B); check(9, 1'b1, 8'h4B);
        drive(0, 0, 0, 1, 1, 8'h00); check(9, 1'b1, 8'h4A);
        drive(0, 0, 0, 1, 1, 8'h00); check(9, 1'b1, 8'h49);
        // R1: reset mid-burst
        rst_n = 1'b0;
        drive(0, 0, 0, 1, 0, 8'h00); check(1, 1'b0, 8'h00);
        rst_n = 1'b1;
        drive(0, 0, 0, 0, 0, 8'h00); check(1, 1'b0, 8'h00);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule